// File: doc/BRIEF.md
# Sectored Flash Program and Erase Engine

This block models the command and timing logic of a small byte-wide flash device with sectors of uneven size. The host sends bus writes, each an address and a data byte, over a valid/ready write stream. Fixed command bytes start a single-byte program or an erase of a chosen set of sectors. A timed engine then changes an internal byte array. While an operation runs, reads return a status byte instead of array data, and a busy output stays high. An erase can be paused so the host can read or program other sectors, and then continued.

The address space holds 128 units. Each unit is `2**UNIT_LG` bytes, which stands for 8 KB of a full-size part. It is cut into 19 sectors: fifteen large sectors of 8 units, one of 4 units, two of 1 unit and one of 2 units. The small sectors sit at the high end of the address space when `BOOT_TOP` is 1 and at the low end when it is 0. With `BOOT_TOP` = 1 the order from the bottom is: sectors 0 to 14 at units 0 to 119, sector 15 at units 120 to 123, sector 16 at unit 124, sector 17 at unit 125 and sector 18 at units 126 and 127.

Write-stream rules: a write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while a program is running. Writes taken while `vlow` is high are consumed but have no effect. The read side takes no back-pressure. A read request on `rd_valid` is answered on `rd_data` in the following cycle, with `rd_dv` high, and the host must accept it.

Top module: `flash_pe_engine`

## Requirements
- R1: Address-to-sector mapping follows the layout above (`BOOT_TOP` = 1: sector 14 ends at unit 119, sector 15 covers units 120 to 123, sector 16 is unit 124). An erase changes only bytes inside the selected sectors.
- R2: A write of 0xA0 followed by a write of address/data programs that byte. The new value is the old value AND the data, so bits can only be cleared. `busy` is high for exactly `PROG_CYC` cycles after the data write, and `wr_ready` is low during that time.
- R3: While a program runs, every read returns bit 7 as the inverse of bit 7 of the data being programmed, and bits 5 to 0 as zero.
- R4: While `busy` is high, bit 6 of the read result changes on each read. Once the operation ends, repeated reads of an address return the same array value.
- R5: An erase starts with a write of 0x80. Each following write of 0x30 adds the sector that holds its address, and a write of 0x10 starts the erase. A write of 0x10 directly after 0x80 erases every unprotected sector. Erased bytes read 0xFF. Any other byte in these steps returns to read mode.
- R6: While an erase runs, reads return bit 7 = 0 and bits 5 to 0 = 0. `busy` is high for exactly `ERASE_CYC` cycles when no suspend occurs.
- R7: A write of 0xB0 during an erase suspends it, and `busy` is low in the next cycle. While suspended, reads of unselected sectors return array data and reads of selected sectors return 0x00. The remaining erase time is kept for as long as the suspend lasts.
- R8: While suspended, 0xA0 followed by address/data programs a byte in an unselected sector, after which the engine is suspended again. A program aimed at a selected sector is rejected and `busy` stays low. A write of 0x30 resumes the erase to completion.
- R9: Sectors whose bit in `prot` is set are never programmed or erased. A program or erase that is left with no permitted target does not raise `busy`.
- R10: Writes taken while `vlow` is high change neither the command state nor the array.
- R11: An asynchronous low level on `rst_n` aborts any operation, clears `busy` at once and returns to read mode. An aborted program leaves its byte unchanged. After reset `busy` = 0 and `wr_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to read mode |
| vlow | input | 1 | Low-supply detect; high causes writes to be ignored |
| prot | input | 19 | Per-sector protection, bit n guards sector n |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready, low while programming |
| wr_addr | input | UNIT_LG+7 | Write byte address |
| wr_data | input | 8 | Write data or command byte |
| rd_valid | input | 1 | Read request |
| rd_addr | input | UNIT_LG+7 | Read byte address |
| rd_data | output | 8 | Array data or status byte |
| rd_dv | output | 1 | rd_data valid, one cycle after rd_valid |
| busy | output | 1 | High while a program or erase is in progress |

## Verification
The bench walks the sector edges around the small top sectors. A mapping that is off by one unit would erase a neighbour or miss the last byte of sector 15. It counts `busy` cycles for both operation types, so an off-by-one counter gives a count one too high or one too low. It checks the polling byte and toggling during a program, and checks that toggling stops afterwards. For suspend, it checks reads of selected and unselected sectors, a program into a free sector and a rejected program into a selected one. A design that kept counting while suspended, or that allowed the rejected program, would show `busy` at the wrong time. Protected sectors, low-supply writes and a reset in the middle of a program are also covered. A bad design there would alter a guarded byte, leave a half-armed command behind, or complete the aborted write.

// File: rtl/flash_pkg.sv
`timescale 1ns/1ps
package flash_pkg;
  localparam int NSECT = 19;
  localparam int NUNIT = 128;
  localparam int SW    = 5;

  typedef enum logic [3:0] {
    ST_READ, ST_ARM_P, ST_ARM_E, ST_SEL, ST_PROG,
    ST_ERASE, ST_SUSP, ST_SUSP_ARM, ST_SUSP_PROG
  } fst_e;

  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_ADD   = 8'h30;
  localparam logic [7:0] CMD_GO    = 8'h10;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;

  // unit index (0..127) to sector number, small sectors at the chosen end
  function automatic logic [SW-1:0] unit_to_sect(input int unsigned u, input bit top);
    if (top) begin
      if (u < 120)       return SW'(u / 8);
      else if (u < 124)  return SW'(15);
      else if (u == 124) return SW'(16);
      else if (u == 125) return SW'(17);
      else               return SW'(18);
    end else begin
      if (u < 2)         return SW'(0);
      else if (u == 2)   return SW'(1);
      else if (u == 3)   return SW'(2);
      else if (u < 8)    return SW'(3);
      else               return SW'(4 + (u - 8) / 8);
    end
  endfunction
endpackage

// File: rtl/flash_sect_map.sv
`timescale 1ns/1ps
module flash_sect_map
  import flash_pkg::*;
#(
  parameter int UNIT_LG  = 2,
  parameter bit BOOT_TOP = 1'b1,
  localparam int AW      = UNIT_LG + 7
) (
  input  logic [AW-1:0] addr,
  output logic [SW-1:0] sect
);
  logic [6:0] unit_idx;
  assign unit_idx = addr[AW-1:UNIT_LG];
  assign sect     = unit_to_sect(32'(unit_idx), BOOT_TOP);
endmodule

// File: rtl/flash_array.sv
`timescale 1ns/1ps
module flash_array
  import flash_pkg::*;
#(
  parameter int UNIT_LG  = 2,
  parameter bit BOOT_TOP = 1'b1,
  localparam int AW      = UNIT_LG + 7,
  localparam int DEPTH   = 1 << AW
) (
  input  logic             clk,
  input  logic [AW-1:0]    raddr,
  output logic [7:0]       rdata,
  input  logic             pg_en,
  input  logic [AW-1:0]    pg_addr,
  input  logic [7:0]       pg_data,
  input  logic             er_en,
  input  logic [NSECT-1:0] er_sel
);
  logic [7:0] mem [DEPTH];

  // array leaves the factory erased
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (pg_en) mem[pg_addr] <= mem[pg_addr] & pg_data;
    if (er_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (er_sel[unit_to_sect(32'(i >> UNIT_LG), BOOT_TOP)]) mem[i] <= 8'hFF;
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
  import flash_pkg::*;
#(
  parameter int UNIT_LG   = 2,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 40,
  localparam int AW       = UNIT_LG + 7,
  localparam int PCW      = $clog2(PROG_CYC + 1),
  localparam int ECW      = $clog2(ERASE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vlow,
  input  logic [NSECT-1:0] prot,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [SW-1:0]    wr_sect,
  input  logic             rd_valid,
  input  logic [SW-1:0]    rd_sect,
  input  logic [7:0]       arr_rdata,
  output logic [7:0]       rd_data,
  output logic             rd_dv,
  output logic             busy,
  output logic             pg_en,
  output logic [AW-1:0]    pg_addr,
  output logic [7:0]       pg_data,
  output logic             er_en,
  output logic [NSECT-1:0] er_sel
);
  fst_e             st;
  logic [PCW-1:0]   pcnt;
  logic [ECW-1:0]   ecnt;
  logic [NSECT-1:0] sel;
  logic             tog;
  logic             wr_fire;
  logic [NSECT-1:0] sect_bit;
  logic             prog_busy;

  assign prog_busy = (st == ST_PROG) || (st == ST_SUSP_PROG);
  assign wr_ready  = !prog_busy;
  assign busy      = prog_busy || (st == ST_ERASE);
  assign wr_fire   = wr_valid && wr_ready && !vlow;
  assign sect_bit  = {{(NSECT-1){1'b0}}, 1'b1} << wr_sect;
  assign pg_en     = prog_busy && (pcnt == '0);
  assign er_en     = (st == ST_ERASE) && (ecnt == '0);
  assign er_sel    = sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_READ;
      pcnt    <= '0;
      ecnt    <= '0;
      sel     <= '0;
      pg_addr <= '0;
      pg_data <= '0;
    end else begin
      unique case (st)
        ST_READ: if (wr_fire) begin
          if (wr_data == CMD_PROG) st <= ST_ARM_P;
          else if (wr_data == CMD_ERASE) begin
            st  <= ST_ARM_E;
            sel <= '0;
          end
        end
        ST_ARM_P: if (wr_fire) begin
          if (!prot[wr_sect]) begin
            pg_addr <= wr_addr;
            pg_data <= wr_data;
            pcnt    <= PCW'(PROG_CYC - 1);
            st      <= ST_PROG;
          end else st <= ST_READ;
        end
        ST_ARM_E: if (wr_fire) begin
          if (wr_data == CMD_ADD) begin
            sel <= sect_bit & ~prot;
            st  <= ST_SEL;
          end else if (wr_data == CMD_GO && (~prot != '0)) begin
            sel  <= ~prot;
            ecnt <= ECW'(ERASE_CYC - 1);
            st   <= ST_ERASE;
          end else st <= ST_READ;
        end
        ST_SEL: if (wr_fire) begin
          if (wr_data == CMD_ADD) sel <= sel | (sect_bit & ~prot);
          else if (wr_data == CMD_GO && sel != '0) begin
            ecnt <= ECW'(ERASE_CYC - 1);
            st   <= ST_ERASE;
          end else begin
            sel <= '0;
            st  <= ST_READ;
          end
        end
        ST_PROG: begin
          if (pcnt == '0) st <= ST_READ;
          else pcnt <= pcnt - 1'b1;
        end
        ST_ERASE: begin
          if (ecnt == '0) begin
            sel <= '0;
            st  <= ST_READ;
          end else if (wr_fire && wr_data == CMD_SUSP) st <= ST_SUSP;
          else ecnt <= ecnt - 1'b1;
        end
        ST_SUSP: if (wr_fire) begin
          if (wr_data == CMD_ADD) st <= ST_ERASE;
          else if (wr_data == CMD_PROG) st <= ST_SUSP_ARM;
        end
        ST_SUSP_ARM: if (wr_fire) begin
          if (!prot[wr_sect] && !sel[wr_sect]) begin
            pg_addr <= wr_addr;
            pg_data <= wr_data;
            pcnt    <= PCW'(PROG_CYC - 1);
            st      <= ST_SUSP_PROG;
          end else st <= ST_SUSP;
        end
        ST_SUSP_PROG: begin
          if (pcnt == '0) st <= ST_SUSP;
          else pcnt <= pcnt - 1'b1;
        end
        default: st <= ST_READ;
      endcase
    end
  end

  // read path: status while busy, hidden bytes while suspended
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_dv   <= 1'b0;
      tog     <= 1'b0;
    end else begin
      rd_dv <= rd_valid;
      if (rd_valid) begin
        if (prog_busy)                        rd_data <= {~pg_data[7], tog, 6'b0};
        else if (st == ST_ERASE)              rd_data <= {1'b0, tog, 6'b0};
        else if (st != ST_READ && sel[rd_sect]) rd_data <= 8'h00;
        else                                  rd_data <= arr_rdata;
        if (busy) tog <= ~tog;
      end
    end
  end

  p_prog_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG && pcnt != '0) |=> (st == ST_PROG));
  p_erase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERASE && ecnt != '0 && !(wr_fire && wr_data == CMD_SUSP)) |=> (st == ST_ERASE));
  p_susp_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP) |=> $stable(ecnt));
  p_prot_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARM_P && wr_fire && prot[wr_sect]) |=> (st == ST_READ));
  p_erase_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    er_en |-> ((er_sel & prot) == '0));
  p_vlow_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && vlow) |=> (st == ST_READ));
endmodule

// File: rtl/flash_pe_engine.sv
`timescale 1ns/1ps
module flash_pe_engine
  import flash_pkg::*;
#(
  parameter int UNIT_LG   = 2,
  parameter bit BOOT_TOP  = 1'b1,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 40,
  localparam int AW       = UNIT_LG + 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vlow,
  input  logic [NSECT-1:0]    prot,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [AW-1:0]       wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                rd_valid,
  input  logic [AW-1:0]       rd_addr,
  output logic [7:0]          rd_data,
  output logic                rd_dv,
  output logic                busy
);
  logic [SW-1:0]    wr_sect, rd_sect;
  logic [7:0]       arr_rdata, pg_data;
  logic [AW-1:0]    pg_addr;
  logic             pg_en, er_en;
  logic [NSECT-1:0] er_sel;

  flash_sect_map #(.UNIT_LG(UNIT_LG), .BOOT_TOP(BOOT_TOP)) u_wmap (.addr(wr_addr), .sect(wr_sect));
  flash_sect_map #(.UNIT_LG(UNIT_LG), .BOOT_TOP(BOOT_TOP)) u_rmap (.addr(rd_addr), .sect(rd_sect));

  flash_array #(.UNIT_LG(UNIT_LG), .BOOT_TOP(BOOT_TOP)) u_arr (
    .clk(clk), .raddr(rd_addr), .rdata(arr_rdata),
    .pg_en(pg_en), .pg_addr(pg_addr), .pg_data(pg_data),
    .er_en(er_en), .er_sel(er_sel)
  );

  flash_cmd_fsm #(.UNIT_LG(UNIT_LG), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .vlow(vlow), .prot(prot),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_sect(wr_sect), .rd_valid(rd_valid), .rd_sect(rd_sect), .arr_rdata(arr_rdata),
    .rd_data(rd_data), .rd_dv(rd_dv), .busy(busy),
    .pg_en(pg_en), .pg_addr(pg_addr), .pg_data(pg_data),
    .er_en(er_en), .er_sel(er_sel)
  );
endmodule

// File: tb/sim_flash_pe_engine.sv
`timescale 1ns/1ps
module sim_flash_pe_engine;
  localparam int UNIT_LG = 2;
  localparam int AW      = UNIT_LG + 7;
  localparam int PCYC    = 6;
  localparam int ECYC    = 40;

  logic clk = 1'b0, rst_n = 1'b0, vlow = 1'b0;
  logic [18:0] prot = '0;
  logic wr_valid = 1'b0, rd_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready, rd_dv, busy;
  logic [7:0] rd_data;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  flash_pe_engine #(.UNIT_LG(UNIT_LG), .BOOT_TOP(1'b1), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)) u0 (
    .clk(clk), .rst_n(rst_n), .vlow(vlow), .prot(prot),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_dv(rd_dv), .busy(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, got cycle %0d expected finish", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    bit ok;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    forever begin
      ok = wr_ready;
      @(negedge clk);
      if (ok) break;
    end
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    v = rd_data;
    rd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 2000) begin n++; @(negedge clk); end
    if (busy) chk("wait_idle timeout", 8'h01, 8'h00);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 2000) begin n++; @(negedge clk); end
  endtask

  // entry: {kind[1:0], addr[15:0], data[7:0], exp[7:0]}; kind 0 write, 1 wait, 2 read-check
  localparam int NV = 37;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0,16'h000,8'hA0,8'h00}, {2'd0,16'h010,8'h5A,8'h00}, {2'd1,16'h0,8'h0,8'h0}, {2'd2,16'h010,8'h0,8'h5A},
    {2'd0,16'h000,8'hA0,8'h00}, {2'd0,16'h010,8'h3C,8'h00}, {2'd1,16'h0,8'h0,8'h0}, {2'd2,16'h010,8'h0,8'h18},
    {2'd0,16'h000,8'hA0,8'h00}, {2'd0,16'h1E0,8'h00,8'h00}, {2'd1,16'h0,8'h0,8'h0},
    {2'd0,16'h000,8'hA0,8'h00}, {2'd0,16'h1F0,8'h11,8'h00}, {2'd1,16'h0,8'h0,8'h0},
    {2'd0,16'h000,8'hA0,8'h00}, {2'd0,16'h1DC,8'h22,8'h00}, {2'd1,16'h0,8'h0,8'h0},
    {2'd0,16'h000,8'h80,8'h00}, {2'd0,16'h1E4,8'h30,8'h00}, {2'd0,16'h000,8'h10,8'h00}, {2'd1,16'h0,8'h0,8'h0},
    {2'd2,16'h1E0,8'h0,8'hFF}, {2'd2,16'h1F0,8'h0,8'h11}, {2'd2,16'h1DC,8'h0,8'h22},
    {2'd0,16'h000,8'hA0,8'h00}, {2'd0,16'h1EC,8'h77,8'h00}, {2'd1,16'h0,8'h0,8'h0}, {2'd2,16'h1EC,8'h0,8'h77},
    {2'd0,16'h000,8'h80,8'h00}, {2'd0,16'h1F0,8'h30,8'h00}, {2'd0,16'h010,8'h30,8'h00}, {2'd0,16'h000,8'h10,8'h00},
    {2'd1,16'h0,8'h0,8'h0}, {2'd2,16'h010,8'h0,8'hFF}, {2'd2,16'h1F0,8'h0,8'hFF}, {2'd2,16'h1EC,8'h0,8'h77},
    {2'd2,16'h1DC,8'h0,8'h22}
  };

  initial begin
    logic [7:0] v, v2;
    int n;
    repeat (3) @(negedge clk);
    // reset state (R11)
    chk("R11 reset busy", {7'b0, busy}, 8'h00);
    chk("R11 reset wr_ready", {7'b0, wr_ready}, 8'h01);
    rst_n = 1'b1;
    rd(9'h100, v); chk("R11 erased after reset", v, 8'hFF);

    // table walk: program AND, sector boundaries, multi-sector erase (R1 R2 R5)
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][33:32])
        2'd0: wr(VEC[i][AW+15:16], VEC[i][15:8]);
        2'd1: wait_idle();
        default: begin
          rd(VEC[i][AW+15:16], v);
          chk($sformatf("table R1 R2 R5 entry %0d", i), v, VEC[i][7:0]);
        end
      endcase
    end

    // program polling and toggle (R3 R4)
    wr(9'h000, 8'hA0); wr(9'h020, 8'h35);
    rd(9'h020, v); rd(9'h020, v2);
    chk("R3 poll bit7 inverted", {v[7], 1'b0, v[5:0]}, 8'h80);
    chk("R4 toggle flips", {7'b0, v[6] ^ v2[6]}, 8'h01);
    wait_idle();
    rd(9'h020, v); rd(9'h020, v2);
    chk("R4 no toggle after done", v2, v);
    chk("R4 data after done", v, 8'h35);

    // program duration and back-pressure (R2)
    wr(9'h000, 8'hA0); wr(9'h024, 8'h81);
    chk("R2 wr_ready low while programming", {7'b0, wr_ready}, 8'h00);
    count_busy(n);
    chk("R2 program busy cycles", 8'(n), 8'(PCYC));

    // erase duration (R6)
    wr(9'h000, 8'hA0); wr(9'h060, 8'h44); wait_idle();
    wr(9'h000, 8'h80); wr(9'h060, 8'h30); wr(9'h000, 8'h10);
    count_busy(n);
    chk("R6 erase busy cycles", 8'(n), 8'(ECYC));
    rd(9'h060, v); chk("R6 sector erased", v, 8'hFF);

    // suspend and resume (R6 R7 R8)
    wr(9'h000, 8'hA0); wr(9'h060, 8'h44); wait_idle();
    wr(9'h000, 8'h80); wr(9'h060, 8'h30); wr(9'h000, 8'h10);
    rd(9'h1EC, v); chk("R6 erase status", {v[7], 1'b0, v[5:0]}, 8'h00);
    wr(9'h000, 8'hB0);
    chk("R7 busy low after suspend", {7'b0, busy}, 8'h00);
    rd(9'h1EC, v); chk("R7 unselected reads data", v, 8'h77);
    rd(9'h060, v); chk("R7 selected reads zero", v, 8'h00);
    repeat (2 * ECYC) @(negedge clk);
    chk("R7 still suspended", {7'b0, busy}, 8'h00);
    rd(9'h064, v); chk("R7 erase not completed", v, 8'h00);
    wr(9'h000, 8'hA0); wr(9'h014, 8'h12);
    chk("R8 program in suspend busy", {7'b0, busy}, 8'h01);
    wait_idle();
    rd(9'h014, v); chk("R8 program in suspend", v, 8'h12);
    wr(9'h000, 8'hA0); wr(9'h064, 8'h00);
    chk("R8 selected sector rejected", {7'b0, busy}, 8'h00);
    wr(9'h000, 8'h30);
    chk("R8 resume busy", {7'b0, busy}, 8'h01);
    wait_idle();
    rd(9'h060, v); chk("R8 erase finished", v, 8'hFF);
    rd(9'h014, v); chk("R8 suspend program kept", v, 8'h12);

    // protection (R9)
    wr(9'h000, 8'hA0); wr(9'h0A0, 8'h0F); wait_idle();
    wr(9'h000, 8'hA0); wr(9'h0C4, 8'h0F); wait_idle();
    prot = 19'h00020;
    wr(9'h000, 8'hA0); wr(9'h0A4, 8'h00);
    chk("R9 protected program no busy", {7'b0, busy}, 8'h00);
    rd(9'h0A4, v); chk("R9 protected byte kept", v, 8'hFF);
    wr(9'h000, 8'h80); wr(9'h0A0, 8'h30); wr(9'h000, 8'h10);
    chk("R9 protected erase no busy", {7'b0, busy}, 8'h00);
    wr(9'h000, 8'h80); wr(9'h0A0, 8'h30); wr(9'h0C4, 8'h30); wr(9'h000, 8'h10);
    wait_idle();
    rd(9'h0A0, v); chk("R9 protected sector kept", v, 8'h0F);
    rd(9'h0C4, v); chk("R9 neighbour erased", v, 8'hFF);
    prot = '0;

    // low supply (R10)
    vlow = 1'b1;
    wr(9'h000, 8'hA0); wr(9'h030, 8'h00);
    chk("R10 no busy under vlow", {7'b0, busy}, 8'h00);
    vlow = 1'b0;
    rd(9'h030, v); chk("R10 byte unchanged", v, 8'hFF);
    wr(9'h030, 8'h5A);
    rd(9'h030, v); chk("R10 no leftover arm", v, 8'hFF);

    // reset mid-program (R11)
    wr(9'h000, 8'hA0); wr(9'h040, 8'h00);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R11 busy cleared by reset", {7'b0, busy}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    rd(9'h040, v); chk("R11 aborted byte unchanged", v, 8'hFF);
    chk("R11 wr_ready after reset", {7'b0, wr_ready}, 8'h01);

    // whole-chip erase (R5 R6)
    wr(9'h000, 8'h80); wr(9'h000, 8'h10);
    count_busy(n);
    chk("R6 chip erase busy cycles", 8'(n), 8'(ECYC));
    rd(9'h1EC, v); chk("R5 chip erase top", v, 8'hFF);
    rd(9'h014, v); chk("R5 chip erase bottom", v, 8'hFF);
    rd(9'h1DC, v); chk("R5 chip erase middle", v, 8'hFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule